// File: doc/BRIEF.md
# SIMT Divergence and Reconvergence Stack

This block keeps the program counter and the active lane mask of one warp in a SIMT core. Every step the warp issues one instruction at the fetch PC, and all lanes in the active mask execute it together. When that instruction is a branch, the block receives a per-lane taken mask together with the target PC, the fall-through PC and the PC at which the two paths meet again. It then returns the PC of the next instruction and the set of lanes that will run it.

A branch that splits the active lanes is handled with a hardware stack. Each entry holds a PC, a lane mask and a reconvergence PC. The entry on top describes the path that is running now. On a split, the current entry is turned into a reconvergence entry and the two paths are pushed above it. The taken path goes on top, so it runs first, and the not-taken lanes wait beneath it. A path ends when its next PC equals its reconvergence PC. The stack is then popped, which starts the waiting path or, once both paths are done, restores the mask from before the split at the meeting point. Paths with no instructions are never pushed. A nested split that meets at the same PC as its enclosing path reuses the enclosing entry. A split that would need more entries than the stack holds raises a sticky overflow flag and stalls the warp.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset, next_pc equals the RESET_PC parameter, active_mask is all ones, and stack_full and overflow are 0.
- R2: A step with is_branch low gives next_pc = fetch_pc + INSTR_BYTES. A cycle with step_valid low leaves next_pc, active_mask and both flags unchanged.
- R3: A branch that all active lanes resolve the same way pushes nothing and keeps the mask. next_pc becomes target_pc if all of them are taken, or fallthru_pc if none is taken.
- R4: Bits of taken_mask that belong to lanes outside active_mask have no effect on the outcome.
- R5: On a split branch (some active lanes taken and some not), next_pc becomes target_pc and active_mask becomes the taken active lanes. The not-taken active lanes are deferred with fallthru_pc. The new mask is always a subset of the old one.
- R6: When a step's next PC equals the reconvergence PC of the running path and that path is not the bottom entry, the stack pops. next_pc and active_mask then come from the entry below.
- R7: When the last deferred path of a split reaches the reconvergence PC, next_pc becomes that PC and active_mask becomes the mask from before the split.
- R8: A path whose start PC equals the reconvergence PC is not pushed. If target_pc equals reconv_pc, the not-taken lanes run at once. If fallthru_pc equals reconv_pc, only the taken path is pushed.
- R9: A split inside a path whose reconvergence PC equals the new reconv_pc reuses that path's entry, so it grows the stack by one entry instead of two.
- R10: stack_full is 1 exactly when all DEPTH entries are in use.
- R11: A split that needs more than DEPTH entries sets overflow, which stays set until reset. In that step next_pc becomes fetch_pc and active_mask does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_valid | input | 1 | The warp issues the instruction at fetch_pc this cycle |
| is_branch | input | 1 | The issued instruction is a conditional branch |
| taken_mask | input | LANES | Per-lane branch outcome, 1 = taken |
| target_pc | input | PC_W | Branch target PC |
| fallthru_pc | input | PC_W | PC after the branch when not taken |
| reconv_pc | input | PC_W | PC where the two paths meet again |
| fetch_pc | input | PC_W | PC of the issued instruction |
| next_pc | output | PC_W | PC the warp fetches next |
| active_mask | output | LANES | Lanes enabled for the next instruction |
| stack_full | output | 1 | All stack entries are in use |
| overflow | output | 1 | Sticky flag: a split did not fit in the stack |

## Verification
The assertions check, on every cycle, that the active mask is never empty and that idle cycles hold the PC and the mask. They also check that a split never enables a lane that was off before it, and that overflow is sticky and stalls the warp with its mask unchanged. Several behaviours can only be shown by the bench's scenarios, because they depend on the order of pushes and pops over many steps. These are the taken-first order, the pop into the deferred path, the restore of the earlier mask at the meeting point, the skipping of empty paths, the reuse of an entry for nested splits, and the exact step at which the stack fills.

// File: rtl/simt_reconv_pkg.sv
package simt_reconv_pkg;

    // Classification of one issued step.
    typedef enum logic [1:0] {
        STEP_IDLE  = 2'd0,
        STEP_FLOW  = 2'd1,   // sequential or uniform branch, may pop
        STEP_SPLIT = 2'd2    // lanes diverge, pushes entries
    } step_kind_e;

endpackage

// File: rtl/simt_lane_split.sv
module simt_lane_split #(
    parameter int LANES = 8
) (
    input  logic [LANES-1:0] active,
    input  logic [LANES-1:0] taken_raw,
    output logic [LANES-1:0] taken_act,
    output logic [LANES-1:0] fall_act,
    output logic             all_taken,
    output logic             none_taken
);

    always_comb begin
        taken_act  = taken_raw & active;
        fall_act   = ~taken_raw & active;
        all_taken  = (fall_act == '0);
        none_taken = (taken_act == '0);
    end

endmodule

// File: rtl/simt_pc_pick.sv
module simt_pc_pick #(
    parameter int PC_W        = 32,
    parameter int INSTR_BYTES = 4
) (
    input  logic            is_branch,
    input  logic            none_taken,
    input  logic [PC_W-1:0] fetch_pc,
    input  logic [PC_W-1:0] target_pc,
    input  logic [PC_W-1:0] fallthru_pc,
    output logic [PC_W-1:0] cand_pc
);

    localparam logic [PC_W-1:0] PC_STEP = PC_W'(INSTR_BYTES);

    always_comb begin
        if (!is_branch) begin
            cand_pc = fetch_pc + PC_STEP;
        end else if (none_taken) begin
            cand_pc = fallthru_pc;
        end else begin
            cand_pc = target_pc;
        end
    end

endmodule

// File: rtl/simt_stack_store.sv
module simt_stack_store #(
    parameter int LANES = 8,
    parameter int PC_W  = 32,
    parameter int DEPTH = 8,
    parameter int NWP   = 3,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NWP-1:0]                  wr_en,
    input  logic [NWP-1:0][PTR_W-1:0]       wr_idx,
    input  logic [NWP-1:0][PC_W-1:0]        wr_pc,
    input  logic [NWP-1:0][LANES-1:0]       wr_mask,
    input  logic [NWP-1:0][PC_W-1:0]        wr_rpc,
    input  logic [PTR_W-1:0]                top_idx,
    input  logic [PTR_W-1:0]                below_idx,
    output logic [LANES-1:0]                top_mask,
    output logic [PC_W-1:0]                 top_rpc,
    output logic [PC_W-1:0]                 below_pc
);

    typedef struct packed {
        logic [PC_W-1:0]  pc;
        logic [LANES-1:0] mask;
        logic [PC_W-1:0]  rpc;
    } slot_t;

    slot_t [DEPTH-1:0] mem_d;
    slot_t [DEPTH-1:0] mem_q;

    // Next-state: later ports override earlier ones on the same slot.
    always_comb begin
        mem_d = mem_q;
        for (int p = 0; p < NWP; p++) begin
            for (int d = 0; d < DEPTH; d++) begin
                if (wr_en[p] && (wr_idx[p] == PTR_W'(d))) begin
                    mem_d[d].pc   = wr_pc[p];
                    mem_d[d].mask = wr_mask[p];
                    mem_d[d].rpc  = wr_rpc[p];
                end
            end
        end
    end

    // Read muxes guarded against indices beyond DEPTH-1.
    always_comb begin
        top_mask = '0;
        top_rpc  = '0;
        below_pc = '0;
        for (int d = 0; d < DEPTH; d++) begin
            if (top_idx == PTR_W'(d)) begin
                top_mask = mem_q[d].mask;
                top_rpc  = mem_q[d].rpc;
            end
            if (below_idx == PTR_W'(d)) begin
                below_pc = mem_q[d].pc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int d = 0; d < DEPTH; d++) begin
                mem_q[d] <= '0;
            end
            mem_q[0].mask <= '1;
            mem_q[0].rpc  <= '1;
        end else begin
            mem_q <= mem_d;
        end
    end

endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
    import simt_reconv_pkg::*;
#(
    parameter int              LANES       = 8,
    parameter int              PC_W        = 32,
    parameter int              DEPTH       = 8,
    parameter int              INSTR_BYTES = 4,
    parameter logic [PC_W-1:0] RESET_PC    = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_valid,
    input  logic             is_branch,
    input  logic [LANES-1:0] taken_mask,
    input  logic [PC_W-1:0]  target_pc,
    input  logic [PC_W-1:0]  fallthru_pc,
    input  logic [PC_W-1:0]  reconv_pc,
    input  logic [PC_W-1:0]  fetch_pc,
    output logic [PC_W-1:0]  next_pc,
    output logic [LANES-1:0] active_mask,
    output logic             stack_full,
    output logic             overflow
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 2;
    localparam int NWP   = 3;
    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(DEPTH - 1);

    typedef struct packed {
        logic [PC_W-1:0]  pc;
        logic [PTR_W-1:0] top;
        logic             ovf;
    } state_t;

    state_t st_d, st_q;

    // Stack read data
    logic [LANES-1:0] top_mask;
    logic [PC_W-1:0]  top_rpc;
    logic [PC_W-1:0]  below_pc;
    logic [PTR_W-1:0] below_idx;

    // Stack write ports
    logic [NWP-1:0]             wr_en;
    logic [NWP-1:0][PTR_W-1:0]  wr_idx;
    logic [NWP-1:0][PC_W-1:0]   wr_pc;
    logic [NWP-1:0][LANES-1:0]  wr_mask;
    logic [NWP-1:0][PC_W-1:0]   wr_rpc;

    // Lane classification and candidate PC
    logic [LANES-1:0] taken_act, fall_act;
    logic             all_taken, none_taken;
    logic [PC_W-1:0]  cand_pc;

    step_kind_e       kind;
    logic             share, has_nt, has_tk, at_bottom;
    logic [CNT_W-1:0] base, n_new, new_top;

    assign below_idx = (st_q.top == '0) ? '0 : st_q.top - PTR_W'(1);

    simt_lane_split #(.LANES(LANES)) u_split (
        .active     (top_mask),
        .taken_raw  (taken_mask),
        .taken_act  (taken_act),
        .fall_act   (fall_act),
        .all_taken  (all_taken),
        .none_taken (none_taken)
    );

    simt_pc_pick #(.PC_W(PC_W), .INSTR_BYTES(INSTR_BYTES)) u_pick (
        .is_branch   (is_branch),
        .none_taken  (none_taken),
        .fetch_pc    (fetch_pc),
        .target_pc   (target_pc),
        .fallthru_pc (fallthru_pc),
        .cand_pc     (cand_pc)
    );

    simt_stack_store #(
        .LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH), .NWP(NWP), .PTR_W(PTR_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_pc     (wr_pc),
        .wr_mask   (wr_mask),
        .wr_rpc    (wr_rpc),
        .top_idx   (st_q.top),
        .below_idx (below_idx),
        .top_mask  (top_mask),
        .top_rpc   (top_rpc),
        .below_pc  (below_pc)
    );

    // Step classification
    always_comb begin
        at_bottom = (st_q.top == '0);
        has_nt    = (fallthru_pc != reconv_pc);
        has_tk    = (target_pc != reconv_pc);
        if (!step_valid) begin
            kind = STEP_IDLE;
        end else if (is_branch && !all_taken && !none_taken && (has_nt || has_tk)) begin
            kind = STEP_SPLIT;
        end else begin
            kind = STEP_FLOW;
        end
        share   = !at_bottom && (reconv_pc == top_rpc);
        n_new   = CNT_W'(has_nt) + CNT_W'(has_tk);
        base    = share ? CNT_W'(st_q.top) : CNT_W'(st_q.top) + CNT_W'(1);
        new_top = base + n_new - CNT_W'(1);
    end

    // Next state and stack writes
    always_comb begin
        st_d    = st_q;
        wr_en   = '0;
        wr_idx  = '0;
        wr_pc   = '0;
        wr_mask = '0;
        wr_rpc  = '0;
        unique case (kind)
            STEP_FLOW: begin
                if (!at_bottom && (cand_pc == top_rpc)) begin
                    st_d.top = below_idx;
                    st_d.pc  = below_pc;
                end else begin
                    st_d.pc  = cand_pc;
                end
            end
            STEP_SPLIT: begin
                if (new_top > LAST_SLOT) begin
                    st_d.ovf = 1'b1;
                    st_d.pc  = fetch_pc;
                end else begin
                    // Running entry becomes the reconvergence entry.
                    wr_en[0]   = !share;
                    wr_idx[0]  = st_q.top;
                    wr_pc[0]   = reconv_pc;
                    wr_mask[0] = top_mask;
                    wr_rpc[0]  = top_rpc;
                    // First new entry: deferred lanes if any, else taken lanes.
                    wr_en[1]   = 1'b1;
                    wr_idx[1]  = base[PTR_W-1:0];
                    wr_pc[1]   = has_nt ? fallthru_pc : target_pc;
                    wr_mask[1] = has_nt ? fall_act : taken_act;
                    wr_rpc[1]  = reconv_pc;
                    // Second new entry: taken lanes above the deferred ones.
                    wr_en[2]   = has_nt && has_tk;
                    wr_idx[2]  = base[PTR_W-1:0] + PTR_W'(1);
                    wr_pc[2]   = target_pc;
                    wr_mask[2] = taken_act;
                    wr_rpc[2]  = reconv_pc;
                    st_d.top   = new_top[PTR_W-1:0];
                    st_d.pc    = has_tk ? target_pc : fallthru_pc;
                end
            end
            default: begin
                st_d = st_q;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pc  <= RESET_PC;
            st_q.top <= '0;
            st_q.ovf <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign next_pc     = st_q.pc;
    assign active_mask = top_mask;
    assign stack_full  = (CNT_W'(st_q.top) == LAST_SLOT);
    assign overflow    = st_q.ovf;

endmodule

// File: rtl/simt_reconv_stack_chk.sv
module simt_reconv_stack_chk #(
    parameter int LANES = 8,
    parameter int PC_W  = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             step_valid,
    input logic             is_branch,
    input logic [LANES-1:0] taken_mask,
    input logic [PC_W-1:0]  fetch_pc,
    input logic [PC_W-1:0]  next_pc,
    input logic [LANES-1:0] active_mask,
    input logic             overflow
);

    logic split_now;
    assign split_now = step_valid && is_branch &&
                       ((taken_mask & active_mask) != '0) &&
                       ((~taken_mask & active_mask) != '0);

    // R5: some lane always runs.
    assert_mask_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
        active_mask != '0);

    // R2: idle cycles hold PC and mask.
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !step_valid |=> ($stable(next_pc) && $stable(active_mask)));

    // R5: a split never enables a lane that was off.
    assert_split_subset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        split_now |=> ((active_mask & ~$past(active_mask)) == '0));

    // R11: overflow is sticky.
    assert_overflow_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R11: the overflowing step stalls at its own PC with the mask kept.
    assert_overflow_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> ((next_pc == $past(fetch_pc)) &&
                             (active_mask == $past(active_mask))));

endmodule

bind simt_reconv_stack simt_reconv_stack_chk #(.LANES(LANES), .PC_W(PC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_valid  (step_valid),
    .is_branch   (is_branch),
    .taken_mask  (taken_mask),
    .fetch_pc    (fetch_pc),
    .next_pc     (next_pc),
    .active_mask (active_mask),
    .overflow    (overflow)
);

// File: tb/simt_reconv_stack_tb.sv
module simt_reconv_stack_tb;

    localparam int LANES = 8;
    localparam int PC_W  = 32;
    localparam int DEPTH = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             step_valid = 1'b0;
    logic             is_branch = 1'b0;
    logic [LANES-1:0] taken_mask = '0;
    logic [PC_W-1:0]  target_pc = '0;
    logic [PC_W-1:0]  fallthru_pc = '0;
    logic [PC_W-1:0]  reconv_pc = '0;
    logic [PC_W-1:0]  fetch_pc = '0;
    logic [PC_W-1:0]  next_pc;
    logic [LANES-1:0] active_mask;
    logic             stack_full;
    logic             overflow;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    simt_reconv_stack #(
        .LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH), .INSTR_BYTES(4),
        .RESET_PC(32'h100)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .is_branch(is_branch),
        .taken_mask(taken_mask), .target_pc(target_pc), .fallthru_pc(fallthru_pc),
        .reconv_pc(reconv_pc), .fetch_pc(fetch_pc), .next_pc(next_pc),
        .active_mask(active_mask), .stack_full(stack_full), .overflow(overflow)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic expect_state(input string req, input logic [31:0] pc,
                                input logic [7:0] mask);
        check({req, " pc"}, next_pc, pc);
        check({req, " mask"}, 32'(active_mask), 32'(mask));
    endtask

    task automatic seq_step(input logic [31:0] pc);
        @(negedge clk);
        step_valid = 1'b1;
        is_branch  = 1'b0;
        fetch_pc   = pc;
        @(posedge clk);
        #1;
        step_valid = 1'b0;
    endtask

    task automatic br_step(input logic [31:0] pc, input logic [7:0] tmask,
                           input logic [31:0] tgt, input logic [31:0] fall,
                           input logic [31:0] rpc);
        @(negedge clk);
        step_valid  = 1'b1;
        is_branch   = 1'b1;
        fetch_pc    = pc;
        taken_mask  = tmask;
        target_pc   = tgt;
        fallthru_pc = fall;
        reconv_pc   = rpc;
        @(posedge clk);
        #1;
        step_valid = 1'b0;
        is_branch  = 1'b0;
    endtask

    task automatic t_reset;
        expect_state("R1 reset", 32'h100, 8'hFF);
        check("R1 reset full", 32'(stack_full), 32'd0);
        check("R1 reset overflow", 32'(overflow), 32'd0);
    endtask

    task automatic t_seq_idle;
        seq_step(32'h100);
        expect_state("R2 sequential", 32'h104, 8'hFF);
        @(negedge clk);
        is_branch  = 1'b1;
        taken_mask = 8'h0F;
        target_pc  = 32'hDEAD0;
        fetch_pc   = 32'h999;
        @(posedge clk);
        #1;
        is_branch = 1'b0;
        expect_state("R2 idle hold", 32'h104, 8'hFF);
    endtask

    task automatic t_uniform;
        br_step(32'h104, 8'hFF, 32'h200, 32'h108, 32'h900);
        expect_state("R3 all taken", 32'h200, 8'hFF);
        br_step(32'h200, 8'h00, 32'h900, 32'h204, 32'h990);
        expect_state("R3 none taken", 32'h204, 8'hFF);
        check("R3 no push", 32'(stack_full), 32'd0);
    endtask

    task automatic t_diverge;
        br_step(32'h200, 8'h0F, 32'h300, 32'h204, 32'h400);
        expect_state("R5 taken path first", 32'h300, 8'h0F);
        seq_step(32'h300);
        expect_state("R5 taken path runs", 32'h304, 8'h0F);
        // inactive lanes claim taken; active lanes all fall through
        br_step(32'h304, 8'hF0, 32'h500, 32'h308, 32'h600);
        expect_state("R4 inactive bits ignored", 32'h308, 8'h0F);
        seq_step(32'h3FC);
        expect_state("R6 pop to deferred path", 32'h204, 8'hF0);
        br_step(32'h204, 8'hFF, 32'h400, 32'h208, 32'h700);
        expect_state("R7 restore at reconvergence", 32'h400, 8'hFF);
    endtask

    task automatic t_empty_path;
        br_step(32'h400, 8'h33, 32'h480, 32'h404, 32'h480);
        expect_state("R8 empty taken path skipped", 32'h404, 8'hCC);
        seq_step(32'h47C);
        expect_state("R8 reconverge after not-taken", 32'h480, 8'hFF);
        br_step(32'h480, 8'h81, 32'h700, 32'h484, 32'h484);
        expect_state("R8 empty fallthrough skipped", 32'h700, 8'h81);
        br_step(32'h700, 8'hFF, 32'h484, 32'h704, 32'h999);
        expect_state("R8 reconverge after taken", 32'h484, 8'hFF);
    endtask

    task automatic t_nested_share;
        br_step(32'h900, 8'h0F, 32'h1000, 32'h2000, 32'h3000);
        expect_state("R9 outer split", 32'h1000, 8'h0F);
        check("R10 not full at three entries", 32'(stack_full), 32'd0);
        br_step(32'h1000, 8'h03, 32'h1100, 32'h1004, 32'h3000);
        expect_state("R9 inner split", 32'h1100, 8'h03);
        check("R10 full at four entries", 32'(stack_full), 32'd1);
        check("R9 shared entry no overflow", 32'(overflow), 32'd0);
        seq_step(32'h2FFC);
        expect_state("R9 inner deferred", 32'h1004, 8'h0C);
        check("R10 full clears on pop", 32'(stack_full), 32'd0);
        seq_step(32'h2FFC);
        expect_state("R9 outer deferred", 32'h2000, 8'hF0);
        seq_step(32'h2FFC);
        expect_state("R7 nested restore", 32'h3000, 8'hFF);
    endtask

    task automatic t_overflow;
        br_step(32'h3000, 8'h0F, 32'h4000, 32'h3004, 32'h5000);
        expect_state("R11 setup split", 32'h4000, 8'h0F);
        br_step(32'h4000, 8'h03, 32'h4100, 32'h4004, 32'h4800);
        check("R11 overflow set", 32'(overflow), 32'd1);
        expect_state("R11 stall", 32'h4000, 8'h0F);
        seq_step(32'h4000);
        check("R11 overflow sticky", 32'(overflow), 32'd1);
        expect_state("R11 continues", 32'h4004, 8'h0F);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_seq_idle();
        t_uniform();
        t_diverge();
        t_empty_path();
        t_nested_share();
        t_overflow();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule